// File: doc/BRIEF.md
# Synchronous Serial Master Transceiver with Gated Bit Clock

This block is the transmit and receive engine of a serial port working as a synchronous master. Each word handed to it over a valid/ready handshake goes out on the transmit line as a framed character: a low start bit, then the data bits least significant first, then a high stop bit. Alongside the data, the block drives a serial clock output for the slave. That clock toggles only inside data bits and rests at a programmable level at all other times.

While the word goes out, the block reads the slave's reply on the receive input. It takes one sample per data bit, exactly at the capture edge of the serial clock. The sample point is the middle of the bit for all four polarity and phase settings. The assembled word is then presented with a one-cycle strobe.

Bit timing comes from a programmable divider. The divider gives a tick every `div` system clocks, and a bit lasts sixteen ticks. Word length (8 or 9 bits), clock polarity, clock phase and the choice to pulse the clock on the last data bit are loaded through a write port. That port takes effect only while the block is idle.

Top module: `usync_xcvr`

## Requirements
- R1: With the block idle, `tx_o` is high. A frame is one low start bit, the data bits least significant first, then one high stop bit. Every bit lasts 16 × max(`div`,1) clock cycles, counted from the clock edge that accepts the word.
- R2: With `cfg_nine`=1 a frame carries 9 data bits (`tx_data[0]` to `tx_data[8]`). With `cfg_nine`=0 it carries 8 data bits, and `tx_data[8]` has no effect on `tx_o`.
- R3: `sclk_o` sits at the `cfg_cpol` level while idle, during start and stop bits, and from the cycle after an idle configuration write.
- R4: Within a data bit that is clocked, `sclk_o` takes the level opposite to `cfg_cpol`. With `cfg_cpha`=1 it does so during the first 8 ticks of the bit, and with `cfg_cpha`=0 during the last 8 ticks. The edge at mid-bit is the capture strobe.
- R5: With `cfg_lastclk`=0 the final data bit carries no clock pulse, and `sclk_o` stays at the `cfg_cpol` level for that bit. With `cfg_lastclk`=1 the final data bit is clocked like the others.
- R6: `rx_i` is sampled once per data bit, at the mid-bit clock edge, which ends tick 7 of the bit. Only the value held during ticks 7 and 8 of the bit (one sixteenth of a bit on each side of the strobe) enters the received word.
- R7: `rx_valid` is high for exactly one cycle, the cycle that starts tick 8 of the final data bit. In that cycle `rx_data` holds the received bits with the first received bit in bit 0. With `cfg_nine`=0 it holds 8 bits and bit 8 reads 0.
- R8: `tx_ready` is high while idle and during the final clock cycle of a stop bit. A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `busy` is high from that edge until the end of the stop bit. A word accepted at the end of a stop bit starts its start bit with no idle gap.
- R9: A configuration write (`cfg_we`=1) takes effect only while `busy` is low. A write made while busy changes neither the frame in progress nor the later idle clock level.
- R10: During and after reset: `tx_o`=1, `sclk_o`=0, `busy`=0, `tx_ready`=1, `rx_valid`=0 and `rx_data`=0.
- R11: A divider value of 0 behaves as a value of 1: one tick per clock cycle and a 16-cycle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe, honoured only while idle |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_cpol | input | 1 | Serial clock rest level |
| cfg_cpha | input | 1 | 1: clock active in first half of each bit; 0: in second half |
| cfg_lastclk | input | 1 | 1: pulse the clock on the final data bit |
| cfg_div | input | DIV_W | System clocks per oversampling tick (0 acts as 1) |
| tx_data | input | WORD_W | Word to send |
| tx_valid | input | 1 | Word on tx_data is valid |
| tx_ready | output | 1 | Block accepts a word on this edge |
| tx_o | output | 1 | Serial data out |
| sclk_o | output | 1 | Serial clock out |
| rx_i | input | 1 | Serial data in from the slave |
| rx_data | output | WORD_W | Received word |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| busy | output | 1 | A frame is in progress |

## Verification
The hardest case to reach from the ports is the one where the receive sample lands at the exact boundary of the one-sixteenth-bit window. The stimulus must also show that values outside that window are ignored. The bench counts cycles from the accepting edge and drives `rx_i` to the true bit only during ticks 7 and 8 of each data bit, with the inverse at all other times. An early or late sample therefore corrupts the word. Chains of back-to-back words, together with configuration writes fired in the middle of a frame, exercise the single-cycle ready window at the end of the stop bit and the rule that blocks writes while busy.

// File: rtl/usync_pkg.sv
package usync_pkg;

    // Frame sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } fsm_e;

    // Mode bits held between idle writes
    typedef struct packed {
        logic nine;     // long word when set
        logic cpol;     // clock rest level
        logic cpha;     // clock active in first half of bit when set
        logic lastclk;  // pulse the clock on the final data bit
    } mode_t;

    // Index of the final data bit for a word of width w (long) or w-1 (short)
    function automatic int unsigned last_index(input logic nine, input int unsigned w);
        return nine ? (w - 1) : (w - 2);
    endfunction

    // Serial clock level for a given activity flag
    function automatic logic pulse_level(input mode_t m, input logic active);
        return active ? ~m.cpol : m.cpol;
    endfunction

endpackage

// File: rtl/usync_baud.sv
module usync_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // zero divider acts as one
    assign lim  = (div == '0) ? '0 : (div - ONE);
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end

endmodule

// File: rtl/usync_seq.sv
module usync_seq
    import usync_pkg::*;
#(
    parameter int WORD_W = 9,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  mode_t             mode,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              busy,
    output logic              tx_o,
    output logic              sclk_o,
    output logic              cap,
    output logic              cap_last
);
    localparam int PH_W  = $clog2(OVS);
    localparam int BIT_W = $clog2(WORD_W + 1);
    localparam int HALF  = OVS / 2;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);
    localparam logic [PH_W-1:0] PH_PRE  = PH_W'(HALF - 1);
    localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);
    localparam logic [BIT_W-1:0] BI_ONE = BIT_W'(1);

    fsm_e              st, nxt_st;
    logic [PH_W-1:0]   ph, nxt_ph;
    logic [BIT_W-1:0]  bidx, nxt_bidx;
    logic [WORD_W-1:0] sh, nxt_sh;
    logic [BIT_W-1:0]  lastb;
    logic              bit_end;
    logic              take;
    logic              tx_d;
    logic              sclk_d;
    logic              in_data;
    logic              quiet_last;
    logic              first_half;
    logic              active;

    assign lastb = BIT_W'(last_index(mode.nine, WORD_W));
    assign busy  = (st != ST_IDLE);

    // state, phase, bit index and shift register
    always_comb begin
        nxt_st   = st;
        nxt_ph   = ph;
        nxt_bidx = bidx;
        nxt_sh   = sh;
        bit_end  = tick && (ph == PH_LAST);
        tx_ready = (st == ST_IDLE) || ((st == ST_STOP) && bit_end);
        take     = tx_ready && tx_valid;
        if (tick) begin
            nxt_ph = bit_end ? '0 : (ph + PH_ONE);
        end
        case (st)
            ST_IDLE: begin
                if (take) begin
                    nxt_st   = ST_START;
                    nxt_ph   = '0;
                    nxt_bidx = '0;
                    nxt_sh   = tx_data;
                end
            end
            ST_START: begin
                if (bit_end) begin
                    nxt_st   = ST_DATA;
                    nxt_bidx = '0;
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    if (bidx == lastb) begin
                        nxt_st = ST_STOP;
                    end else begin
                        nxt_bidx = bidx + BI_ONE;
                        nxt_sh   = sh >> 1;
                    end
                end
            end
            ST_STOP: begin
                if (bit_end) begin
                    if (take) begin
                        nxt_st   = ST_START;
                        nxt_bidx = '0;
                        nxt_sh   = tx_data;
                    end else begin
                        nxt_st = ST_IDLE;
                    end
                end
            end
            default: nxt_st = ST_IDLE;
        endcase
    end

    // output levels for the next cycle, from next-state values
    always_comb begin
        in_data    = (nxt_st == ST_DATA);
        quiet_last = (nxt_bidx == lastb) && !mode.lastclk;
        first_half = (nxt_ph < PH_HALF);
        active     = in_data && !quiet_last && (mode.cpha ? first_half : !first_half);
        sclk_d     = pulse_level(mode, active);
        case (nxt_st)
            ST_START: tx_d = 1'b0;
            ST_DATA:  tx_d = nxt_sh[0];
            default:  tx_d = 1'b1;
        endcase
    end

    // capture strobe: the edge that ends the tick before mid-bit
    assign cap      = (st == ST_DATA) && tick && (ph == PH_PRE);
    assign cap_last = cap && (bidx == lastb);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            ph     <= '0;
            bidx   <= '0;
            sh     <= '0;
            tx_o   <= 1'b1;
            sclk_o <= 1'b0;
        end else begin
            st     <= nxt_st;
            ph     <= nxt_ph;
            bidx   <= nxt_bidx;
            sh     <= nxt_sh;
            tx_o   <= tx_d;
            sclk_o <= sclk_d;
        end
    end

endmodule

// File: rtl/usync_cap.sv
module usync_cap #(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              cap_last,
    input  logic              nine,
    input  logic              rx_i,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid
);
    logic [WORD_W-1:0] sr;
    logic [WORD_W-1:0] full;

    // first received bit travels down to the low end
    assign full = {rx_i, sr[WORD_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr       <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= cap_last;
            if (cap) begin
                sr <= full;
            end
            if (cap_last) begin
                rx_data <= nine ? full : (full >> 1);
            end
        end
    end

endmodule

// File: rtl/usync_xcvr.sv
module usync_xcvr
    import usync_pkg::*;
#(
    parameter int WORD_W = 9,
    parameter int OVS    = 16,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_nine,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lastclk,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_o,
    output logic              sclk_o,
    input  logic              rx_i,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              busy
);
    localparam logic [DIV_W-1:0] DIV_RST = {{(DIV_W-1){1'b0}}, 1'b1};

    mode_t            mode_q;
    logic [DIV_W-1:0] div_q;
    logic             tick;
    logic             cap;
    logic             cap_last;

    // configuration loads only while no frame is running
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            div_q  <= DIV_RST;
        end else if (cfg_we && !busy) begin
            mode_q <= '{nine: cfg_nine, cpol: cfg_cpol, cpha: cfg_cpha, lastclk: cfg_lastclk};
            div_q  <= cfg_div;
        end
    end

    usync_baud #(.DIV_W(DIV_W)) baud_i (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (div_q),
        .tick (tick)
    );

    usync_seq #(.WORD_W(WORD_W), .OVS(OVS)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mode     (mode_q),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .busy     (busy),
        .tx_o     (tx_o),
        .sclk_o   (sclk_o),
        .cap      (cap),
        .cap_last (cap_last)
    );

    usync_cap #(.WORD_W(WORD_W)) cap_i (
        .clk      (clk),
        .rst      (rst),
        .cap      (cap),
        .cap_last (cap_last),
        .nine     (mode_q.nine),
        .rx_i     (rx_i),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

endmodule

// File: rtl/usync_chk.sv
module usync_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             tx_o,
    input logic             sclk_o,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             rx_valid,
    input logic             cpol_q,
    input logic [3:0]       mode_bits,
    input logic [DIV_W-1:0] div_q
);
    // R1
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_o);

    // R3
    idle_clock_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && $stable(cpol_q)) |-> (sclk_o == cpol_q));

    // R8
    accept_start_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> (busy && !tx_o));

    // R7
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> ($stable(mode_bits) && $stable(div_q)));

endmodule

bind usync_xcvr usync_chk #(.DIV_W(DIV_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .tx_o      (tx_o),
    .sclk_o    (sclk_o),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .cpol_q    (mode_q.cpol),
    .mode_bits (mode_q),
    .div_q     (div_q)
);

// File: tb/usync_xcvr_tb_top.sv
module usync_xcvr_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_nine = 1'b0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic        cfg_lastclk = 1'b0;
    logic [15:0] cfg_div = 16'd1;
    logic [8:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        tx_o;
    logic        sclk_o;
    logic        rx_i = 1'b1;
    logic [8:0]  rx_data;
    logic        rx_valid;
    logic        busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model of the loaded configuration
    bit m_nine = 1'b0;
    bit m_cpol = 1'b0;
    bit m_cpha = 1'b0;
    bit m_last = 1'b0;
    int m_d = 1;
    bit m_div0 = 1'b0;

    always #2 clk = ~clk;

    usync_xcvr dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_nine(cfg_nine),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lastclk(cfg_lastclk),
        .cfg_div(cfg_div), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_o(tx_o), .sclk_o(sclk_o), .rx_i(rx_i),
        .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int nbits();
        return m_nine ? 9 : 8;
    endfunction

    function automatic bit exp_tx(input int c, input logic [8:0] d);
        int s;
        s = c / (16 * m_d);
        if (s == 0) return 1'b0;
        if (s <= nbits()) return d[s-1];
        return 1'b1;
    endfunction

    function automatic bit exp_sclk(input int c);
        int s;
        int ph;
        bit act;
        s  = c / (16 * m_d);
        ph = (c % (16 * m_d)) / m_d;
        if (s < 1 || s > nbits()) return m_cpol;
        if (s == nbits() && !m_last) return m_cpol;
        act = m_cpha ? (ph < 8) : (ph >= 8);
        return act ? ~m_cpol : m_cpol;
    endfunction

    task automatic set_cfg(input bit n, input bit p, input bit h, input bit l, input int dv);
        @(negedge clk);
        cfg_nine = n; cfg_cpol = p; cfg_cpha = h; cfg_lastclk = l;
        cfg_div = 16'(dv); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        m_nine = n; m_cpol = p; m_cpha = h; m_last = l;
        m_d = (dv == 0) ? 1 : dv;
        m_div0 = (dv == 0);
        @(negedge clk);
        chk("R3 idle clock level after write", sclk_o, m_cpol);
        chk("R8 idle not busy", busy, 0);
    endtask

    task automatic send_first(input logic [8:0] d);
        @(negedge clk);
        chk("R8 ready while idle", tx_ready, 1);
        tx_data = d;
        tx_valid = 1'b1;
        @(posedge clk);
    endtask

    // runs one frame, starting right after the accepting edge
    task automatic run_frame(input logic [8:0] d, input logic [8:0] rxw,
                             input bit chain, input logic [8:0] nd, input bit poke);
        int nb;
        int len;
        int vcyc;
        string sreq;
        nb   = nbits();
        len  = 16 * m_d * (nb + 2);
        vcyc = 16 * m_d * nb + 8 * m_d;
        for (int c = 0; c < len; c++) begin
            int s;
            int ph;
            @(negedge clk);
            s  = c / (16 * m_d);
            ph = (c % (16 * m_d)) / m_d;
            if (c == 0) begin
                tx_valid = chain;
                tx_data  = chain ? nd : 9'($urandom);
            end
            if (poke && c == 5) begin
                cfg_we = 1'b1;
                cfg_cpol = ~m_cpol; cfg_cpha = ~m_cpha;
                cfg_nine = ~m_nine; cfg_lastclk = ~m_last;
                cfg_div = 16'(m_d + 1);
            end
            if (poke && c == 6) cfg_we = 1'b0;
            if (m_div0) chk("R11 tx bit with zero divider", tx_o, exp_tx(c, d));
            else if (!m_nine && s == 9) chk("R2 short word stop follows bit 7", tx_o, exp_tx(c, d));
            else chk("R1 tx frame bit", tx_o, exp_tx(c, d));
            if (s < 1 || s > nb) sreq = "R3 clock rest outside data";
            else if (s == nb && !m_last) sreq = "R5 final bit without pulse";
            else sreq = "R4 clock phase in data bit";
            chk(sreq, sclk_o, exp_sclk(c));
            chk(poke ? "R9 busy through frame" : "R8 busy through frame", busy, 1);
            chk("R8 ready only at stop end", tx_ready, (c == len - 1) ? 1 : 0);
            chk("R7 valid pulse timing", rx_valid, (c == vcyc) ? 1 : 0);
            if (c == vcyc)
                chk("R6 received word", rx_data, m_nine ? rxw : {1'b0, rxw[7:0]});
            if (s >= 1 && s <= nb)
                rx_i = (ph == 7 || ph == 8) ? rxw[s-1] : ~rxw[s-1];
            else
                rx_i = 1'($urandom);
        end
    endtask

    task automatic check_idle();
        @(negedge clk);
        chk("R8 idle after frame", busy, 0);
        chk("R1 line high when idle", tx_o, 1);
        chk("R3 clock rest when idle", sclk_o, m_cpol);
        chk("R8 ready after frame", tx_ready, 1);
    endtask

    task automatic one(input logic [8:0] d, input logic [8:0] rxw, input bit poke);
        send_first(d);
        run_frame(d, rxw, 1'b0, 9'd0, poke);
        check_idle();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (4) @(negedge clk);
        // R10 reset values
        chk("R10 tx in reset", tx_o, 1);
        chk("R10 sclk in reset", sclk_o, 0);
        chk("R10 busy in reset", busy, 0);
        chk("R10 ready in reset", tx_ready, 1);
        chk("R10 valid in reset", rx_valid, 0);
        chk("R10 data in reset", rx_data, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 tx after reset", tx_o, 1);
        chk("R10 sclk after reset", sclk_o, 0);

        set_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1);
        one(9'h0A5, 9'h05C, 1'b0);
        set_cfg(1'b1, 1'b1, 1'b1, 1'b1, 2);
        one(9'h1C3, 9'h0F5, 1'b0);
        set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1);
        one(9'h13C, 9'h0AA, 1'b0);
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0, 0);
        one(9'h0E1, 9'h11E, 1'b0);
        set_cfg(1'b0, 1'b1, 1'b1, 1'b1, 3);
        one(9'h055, 9'h1FF, 1'b1);

        // back-to-back chain
        set_cfg(1'b1, 1'b0, 1'b0, 1'b1, 1);
        send_first(9'h101);
        run_frame(9'h101, 9'h0C3, 1'b1, 9'h0FE, 1'b0);
        run_frame(9'h0FE, 9'h13A, 1'b1, 9'h155, 1'b0);
        run_frame(9'h155, 9'h000, 1'b0, 9'h000, 1'b0);
        check_idle();

        // random configurations and chains
        for (int it = 0; it < 12; it++) begin
            int cnt;
            logic [8:0] cur;
            set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 3));
            cnt = $urandom_range(1, 3);
            cur = 9'($urandom);
            send_first(cur);
            for (int k = 0; k < cnt; k++) begin
                logic [8:0] nxt;
                nxt = 9'($urandom);
                run_frame(cur, 9'($urandom), (k < cnt - 1), nxt, (k == 0) && it[0]);
                cur = nxt;
            end
            check_idle();
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

endmodule